// File: doc/BRIEF.md
# Prioritised Exception Cause Selector

This block reduces the set of exception flags raised for one instruction to a single reported cause. A 16-bit flag vector, indexed by cause number, arrives with a 3-bit unit-class select. The block first clears every flag that the selected unit class is not allowed to raise. From the flags that remain, it picks one cause using a fixed priority order that does not follow cause number.

The outputs are a valid flag, the 4-bit cause number and the masked vector. They leave through an optional register stage, selected by the parameter `OutReg`. The default is registered, so each result appears one clock after its inputs.

Top module: `exc_cause_sel`

## Requirements
- R1: The masked output equals the input flags with every bit outside the selected class's set forced to 0; bits inside the set are copied unchanged.
- R2: Class encoding 1 (front-end) passes only causes 0, 1, 2 and 12.
- R3: Class 2 (load) passes only 4, 5 and 13. Class 3 (store address) passes only 6, 7 and 15. Class 4 (atomic) passes the union 4, 5, 6, 7, 13 and 15.
- R4: Class 5 (system register) passes only 2, 3, 8, 9 and 11. Class 6 (fence) passes only cause 2.
- R5: Class 0 (all) passes every defined cause. Bits 10 and 14 are never passed and never reported under any class.
- R6: The reported cause is the highest-ranked set masked bit. The ranks from first to last are 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R7: Valid is 1 exactly when at least one masked bit is set. While valid is 0, the cause output is 0.
- R8: Class encoding 7, which is unassigned, behaves exactly like class 0.
- R9: With `OutReg`=1, the outputs reflect the inputs present at the previous rising clock edge. While reset (active low) is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| flagsIn | input | 16 | Raised exception flags, bit n = cause n |
| unitCls | input | 3 | Unit-class select (encodings in R2 to R5, R8) |
| causeValid | output | 1 | A permitted cause is present |
| causeNum | output | 4 | Selected cause number, 0 when not valid |
| maskedFlags | output | 16 | Flags after the class mask |

## Verification
All three outputs pass through a single register, so every result is due one rising edge after its stimulus is applied. The bench drives flags and class on a falling edge. It then reads the outputs on the next falling edge, after exactly one capture edge and before the next stimulus is applied. The reset check samples while reset is still held, so the cleared outputs are observed before any capture.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;
  localparam int FlagW  = 16;
  localparam int CauseW = $clog2(FlagW);
  localparam int PrioN  = 14;

  typedef enum logic [2:0] {
    CLS_ALL    = 3'd0,
    CLS_FRONT  = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_ATOMIC = 3'd4,
    CLS_SYSREG = 3'd5,
    CLS_FENCE  = 3'd6
  } unit_cls_e;

  typedef struct packed {
    logic [FlagW-1:0] passMask;
    logic             anyPass;
  } sel_strobe_t;

  // rank 0 is the highest priority
  function automatic logic [CauseW-1:0] prioAt(input int idx);
    case (idx)
      0:  prioAt = 4'd3;
      1:  prioAt = 4'd12;
      2:  prioAt = 4'd1;
      3:  prioAt = 4'd2;
      4:  prioAt = 4'd0;
      5:  prioAt = 4'd11;
      6:  prioAt = 4'd9;
      7:  prioAt = 4'd8;
      8:  prioAt = 4'd6;
      9:  prioAt = 4'd4;
      10: prioAt = 4'd15;
      11: prioAt = 4'd13;
      12: prioAt = 4'd7;
      default: prioAt = 4'd5;
    endcase
  endfunction

  function automatic logic [FlagW-1:0] bitOf(input logic [CauseW-1:0] c);
    bitOf = '0;
    bitOf[c] = 1'b1;
  endfunction

  // set of causes ranked strictly above cause c
  function automatic logic [FlagW-1:0] aboveSet(input logic [CauseW-1:0] c);
    logic hit;
    aboveSet = '0;
    hit = 1'b0;
    for (int i = 0; i < PrioN; i++) begin
      if (prioAt(i) == c) hit = 1'b1;
      if (!hit) aboveSet = aboveSet | bitOf(prioAt(i));
    end
  endfunction
endpackage

// File: rtl/exc_cause_ctrl.sv
module exc_cause_ctrl
  import exc_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  unitCls,
  output sel_strobe_t strobe
);
  logic [FlagW-1:0] loadSet, storeSet, frontSet, sysSet, fenceSet, allSet;

  always_comb begin
    frontSet = bitOf(4'd0) | bitOf(4'd1) | bitOf(4'd2) | bitOf(4'd12);
    loadSet  = bitOf(4'd4) | bitOf(4'd5) | bitOf(4'd13);
    storeSet = bitOf(4'd6) | bitOf(4'd7) | bitOf(4'd15);
    sysSet   = bitOf(4'd2) | bitOf(4'd3) | bitOf(4'd8) | bitOf(4'd9) | bitOf(4'd11);
    fenceSet = bitOf(4'd2);
    allSet   = '0;
    for (int i = 0; i < PrioN; i++) allSet = allSet | bitOf(prioAt(i));
  end

  always_comb begin
    case (unitCls)
      CLS_FRONT:  strobe.passMask = frontSet;
      CLS_LOAD:   strobe.passMask = loadSet;
      CLS_STORE:  strobe.passMask = storeSet;
      CLS_ATOMIC: strobe.passMask = loadSet | storeSet;
      CLS_SYSREG: strobe.passMask = sysSet;
      CLS_FENCE:  strobe.passMask = fenceSet;
      default:    strobe.passMask = allSet;
    endcase
    strobe.anyPass = |strobe.passMask;
  end

  // R5
  reserved_never_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.passMask[10] == 1'b0) && (strobe.passMask[14] == 1'b0));
  // R4
  fence_single_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unitCls == CLS_FENCE) |-> ($countones(strobe.passMask) == 1));
  // R8
  unused_enc_is_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unitCls == 3'd7) |-> ($countones(strobe.passMask) == PrioN));
endmodule

// File: rtl/exc_cause_dpath.sv
module exc_cause_dpath
  import exc_sel_pkg::*;
#(
  parameter bit OutReg = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FlagW-1:0]  flagsIn,
  input  sel_strobe_t       strobe,
  output logic              causeValid,
  output logic [CauseW-1:0] causeNum,
  output logic [FlagW-1:0]  maskedFlags
);
  logic [FlagW-1:0]  maskedNxt;
  logic              validNxt;
  logic [CauseW-1:0] causeNxt;

  assign maskedNxt = strobe.anyPass ? (flagsIn & strobe.passMask) : '0;

  // scan from lowest rank upward so the highest rank wins
  always_comb begin
    validNxt = 1'b0;
    causeNxt = '0;
    for (int i = PrioN - 1; i >= 0; i--) begin
      if (maskedNxt[prioAt(i)]) begin
        validNxt = 1'b1;
        causeNxt = prioAt(i);
      end
    end
  end

  generate
    if (OutReg) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          causeValid  <= 1'b0;
          causeNum    <= '0;
          maskedFlags <= '0;
        end else begin
          causeValid  <= validNxt;
          causeNum    <= causeNxt;
          maskedFlags <= maskedNxt;
        end
      end
    end else begin : g_comb
      assign causeValid  = validNxt;
      assign causeNum    = causeNxt;
      assign maskedFlags = maskedNxt;
    end
  endgenerate

  // R7
  valid_iff_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeValid == (maskedFlags != '0));
  // R7
  idle_cause_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !causeValid |-> (causeNum == '0));
  // R6
  cause_is_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeValid |-> maskedFlags[causeNum]);
  // R6
  no_higher_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeValid |-> ((maskedFlags & aboveSet(causeNum)) == '0));
  // R5
  reserved_never_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    causeValid |-> (causeNum != 4'd10 && causeNum != 4'd14));
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_sel_pkg::*;
#(
  parameter bit OutReg = 1'b1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] flagsIn,
  input  logic [2:0]  unitCls,
  output logic        causeValid,
  output logic [3:0]  causeNum,
  output logic [15:0] maskedFlags
);
  sel_strobe_t strobe;

  exc_cause_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .unitCls (unitCls),
    .strobe  (strobe)
  );

  exc_cause_dpath #(.OutReg(OutReg)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .flagsIn     (flagsIn),
    .strobe      (strobe),
    .causeValid  (causeValid),
    .causeNum    (causeNum),
    .maskedFlags (maskedFlags)
  );
endmodule

// File: tb/exc_cause_sel_test.sv
module exc_cause_sel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] flagsIn = '0;
  logic [2:0]  unitCls = '0;
  logic        causeValid;
  logic [3:0]  causeNum;
  logic [15:0] maskedFlags;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  exc_cause_sel uut (
    .clk(clk), .rstN(rstN), .flagsIn(flagsIn), .unitCls(unitCls),
    .causeValid(causeValid), .causeNum(causeNum), .maskedFlags(maskedFlags)
  );

  int rankList[14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};

  function automatic logic [15:0] refMask(input logic [2:0] c);
    case (c)
      3'd1: refMask = 16'h1007;
      3'd2: refMask = 16'h2030;
      3'd3: refMask = 16'h80C0;
      3'd4: refMask = 16'hA0F0;
      3'd5: refMask = 16'h0B0C;
      3'd6: refMask = 16'h0004;
      default: refMask = 16'hBBFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one stimulus, result due one rising edge later
  task automatic applyAndCheck(input string req, input logic [15:0] f, input logic [2:0] c);
    logic [15:0] m;
    logic [3:0]  ec;
    logic        ev;
    @(negedge clk);
    flagsIn = f;
    unitCls = c;
    m  = f & refMask(c);
    ev = (m != 0);
    ec = 0;
    for (int i = 13; i >= 0; i--) if (m[rankList[i]]) ec = 4'(rankList[i]);
    @(negedge clk);
    chk({req, " masked"}, 32'(maskedFlags), 32'(m));
    chk({req, " valid"},  32'(causeValid),  32'(ev));
    chk({req, " cause"},  32'(causeNum),    32'(ec));
  endtask

  task automatic tReset;  // R9
    flagsIn = 16'hFFFF;
    unitCls = 3'd0;
    #25;
    chk("R9 reset valid", 32'(causeValid), 0);
    chk("R9 reset cause", 32'(causeNum), 0);
    chk("R9 reset masked", 32'(maskedFlags), 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tFront;  // R2, R1
    applyAndCheck("R2 front all ones", 16'hFFFF, 3'd1);
    applyAndCheck("R2 front outside only", 16'hEFF8, 3'd1);
    applyAndCheck("R1 front partial", 16'h1001, 3'd1);
  endtask

  task automatic tMem;  // R3
    applyAndCheck("R3 load all ones", 16'hFFFF, 3'd2);
    applyAndCheck("R3 load 13 vs 5", 16'h2020, 3'd2);
    applyAndCheck("R3 store all ones", 16'hFFFF, 3'd3);
    applyAndCheck("R3 store 15 vs 7", 16'h8080, 3'd3);
    applyAndCheck("R3 atomic store over load", 16'hA0F0, 3'd4);
    applyAndCheck("R3 atomic load only", 16'h2030, 3'd4);
  endtask

  task automatic tSysFence;  // R4
    applyAndCheck("R4 sysreg all ones", 16'hFFFF, 3'd5);
    applyAndCheck("R4 sysreg ecalls", 16'h0B00, 3'd5);
    applyAndCheck("R4 fence all ones", 16'hFFFF, 3'd6);
    applyAndCheck("R4 fence no illegal", 16'hFFFB, 3'd6);
  endtask

  task automatic tReserved;  // R5, R7
    applyAndCheck("R5 reserved bits only", 16'h4400, 3'd0);
    chk("R7 idle cause zero", 32'(causeNum), 0);
    applyAndCheck("R5 all passes defined", 16'hBBFF, 3'd0);
    applyAndCheck("R7 no flags", 16'h0000, 3'd5);
  endtask

  task automatic tUnused;  // R8
    applyAndCheck("R8 unused enc all ones", 16'hFFFF, 3'd7);
    applyAndCheck("R8 unused enc loads", 16'h2030, 3'd7);
    applyAndCheck("R8 unused enc reserved", 16'h4400, 3'd7);
  endtask

  task automatic tPriority;  // R6: each adjacent pair, and each cause alone
    for (int i = 0; i < 13; i++) begin
      logic [15:0] f;
      f = '0;
      f[rankList[i]] = 1'b1;
      f[rankList[i+1]] = 1'b1;
      applyAndCheck("R6 adjacent pair", f, 3'd0);
    end
    for (int i = 0; i < 14; i++) begin
      logic [15:0] f;
      f = '0;
      f[rankList[i]] = 1'b1;
      applyAndCheck("R6 single cause", f, 3'd0);
    end
  endtask

  task automatic tRandom;  // R1, R6, R7
    for (int i = 0; i < 400; i++) begin
      logic [15:0] f;
      logic [2:0]  c;
      f = 16'($urandom);
      if (i % 4 == 0) f = f & 16'($urandom);
      c = 3'($urandom);
      applyAndCheck("R1 random", f, c);
    end
  endtask

  initial begin
    tReset();
    tFront();
    tMem();
    tSysFence();
    tReserved();
    tUnused();
    tPriority();
    tRandom();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule